// File: doc/BRIEF.md
# Modem Line Event Detector with Interrupt and Wake Masking

This block watches four modem control inputs (clear-to-send, data-set-ready, ring indicator and carrier detect) and the serial receive line, and turns changes on them into two requests for the rest of a UART.

The first is a modem-status interrupt request. It comes from sticky per-line change flags that the host reads and clears through a small register port. The second is a wake request for an auto-sleep controller. It is formed combinationally from the raw pins, so it still responds while the UART clock is stopped.

Each modem line has its own disable bit. One bit silences that line's interrupt contribution and its wake contribution together. The serial receive line has a separate wake-disable bit. The ring indicator counts only on its falling (trailing) edge. The other three lines count on either edge.

Register map, selected by a 2-bit address:
- Address 0 is the line mask.
- Address 1 is the interrupt enable.
- Address 2 is the modem status. Reading it clears the flags.
- Address 3 is the serial-line wake disable.

Top module: `modem_evt_wake`

## Requirements
- R1: After reset the mask, the interrupt enable and the serial wake disable read 0. The status flags read 0 and `irq_o` is low.
- R2: A change of either polarity on CTS, DSR or DCD sets status bit 0, 1 or 3 respectively. The flag is visible on the third rising clock edge after the pin changes. Status bits 4 to 7 show the synchronised states of CTS, DSR, RI and DCD.
- R3: Status bit 2 is set only when RI goes from 1 to 0. A rising RI sets no flag and raises no wake.
- R4: Status flags stay set until the host reads address 2. That read clears them on its clock edge. If a new change arrives on the same edge, the flag for that change stays set.
- R5: `irq_o` is high exactly when interrupt-enable bit 3 is set and some status flag has its mask bit clear. Mask bit 0 covers CTS, bit 1 DSR, bit 2 RI and bit 3 DCD.
- R6: A masked line still sets its status flag. It does not drive `irq_o`.
- R7: `wake_o` goes high with no clock edge needed while an unmasked modem pin differs from its synchronised state (for RI, only a pin at 0 against a state of 1). It does not depend on the interrupt enable, and it falls once the synchroniser catches up, two edges later.
- R8: Any edge on `sin_i` raises `wake_o` in the same way unless bit 0 of address 3 is set. The serial line sets no status flag.
- R9: Mask bits 7:4, interrupt-enable bits other than 3, and bits 7:1 of address 3 read as 0. Writes to address 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | UART clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cts_i | input | 1 | Clear-to-send pin, asynchronous |
| dsr_i | input | 1 | Data-set-ready pin, asynchronous |
| ri_i | input | 1 | Ring indicator pin, asynchronous |
| dcd_i | input | 1 | Carrier detect pin, asynchronous |
| sin_i | input | 1 | Serial receive line, idle high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears flags at address 2) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from address |
| irq_o | output | 1 | Modem-status interrupt request |
| wake_o | output | 1 | Wake request to the sleep controller |

## Verification
A pin change takes three register stages to reach the flags and `irq_o`: two synchroniser flops and the flag register. The bench drives pins on the falling clock edge and samples 1 ns after the third following rising edge. `wake_o` is combinational from the pins, so it is sampled 1 ns after the pin change. It is sampled again 1 ns after the second rising edge, when the synchroniser has caught up and the request must be gone. For the same-edge race in R4, the read strobe is placed on the exact edge where the synchronised change is first present. Read data is captured before that edge and again on a later read.

// File: rtl/mew_pkg.sv
package mew_pkg;
  localparam int NL = 4;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;
  localparam int IER_MSI_BIT = 3;
  localparam logic [NL-1:0] TRAIL_ONLY = NL'(1) << LN_RI;

  typedef enum logic [AW-1:0] {
    ADDR_MASK  = 2'd0,
    ADDR_IER   = 2'd1,
    ADDR_STAT  = 2'd2,
    ADDR_SWAKE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/mew_sync.sv
module mew_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mew_edge_det.sv
module mew_edge_det #(
  parameter int W = 4,
  parameter logic [W-1:0] TRAIL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    if (TRAIL[i]) begin : g_fall
      assign evt_o[i] = prev_q[i] & ~cur_i[i];
    end else begin : g_any
      assign evt_o[i] = prev_q[i] ^ cur_i[i];
    end
  end
endmodule

// File: rtl/mew_wake.sv
module mew_wake #(
  parameter int W = 5,
  parameter logic [W-1:0] TRAIL = '0
) (
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] dis_i,
  output logic         wake_o
);
  logic [W-1:0] hit;

  for (genvar i = 0; i < W; i++) begin : g_src
    if (TRAIL[i]) begin : g_fall
      assign hit[i] = ~raw_i[i] & sync_i[i];
    end else begin : g_any
      assign hit[i] = raw_i[i] ^ sync_i[i];
    end
  end

  // combinational so a stopped clock still lets a pin change through
  assign wake_o = |(hit & ~dis_i);
endmodule

// File: rtl/mew_regs.sv
module mew_regs
  import mew_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] status_i,
  output logic [NL-1:0] mask_o,
  output logic          msi_en_o,
  output logic          swake_dis_o,
  output logic [DW-1:0] rdata_o
);
  logic [NL-1:0] mask_q;
  logic          msi_en_q;
  logic          swake_dis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q      <= '0;
      msi_en_q    <= 1'b0;
      swake_dis_q <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        ADDR_MASK:  mask_q      <= wdata_i[NL-1:0];
        ADDR_IER:   msi_en_q    <= wdata_i[IER_MSI_BIT];
        ADDR_SWAKE: swake_dis_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_MASK:  rdata_o[NL-1:0]     = mask_q;
      ADDR_IER:   rdata_o[IER_MSI_BIT] = msi_en_q;
      ADDR_STAT:  rdata_o             = status_i;
      ADDR_SWAKE: rdata_o[0]          = swake_dis_q;
      default: ;
    endcase
  end

  assign mask_o      = mask_q;
  assign msi_en_o    = msi_en_q;
  assign swake_dis_o = swake_dis_q;
endmodule

// File: rtl/modem_evt_wake.sv
module modem_evt_wake
  import mew_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cts_i,
  input  logic          dsr_i,
  input  logic          ri_i,
  input  logic          dcd_i,
  input  logic          sin_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o,
  output logic          wake_o
);
  localparam int SW = NL + 1;
  localparam logic [SW-1:0] SYNC_RST = SW'(1) << NL;  // serial line idles high
  localparam logic [SW-1:0] WAKE_TRAIL = {1'b0, TRAIL_ONLY};

  logic [SW-1:0] raw, sync;
  logic [NL-1:0] evt, flag_q, mask;
  logic          msi_en, swake_dis, rd_stat;
  logic [DW-1:0] status;

  assign raw = {sin_i, dcd_i, ri_i, dsr_i, cts_i};

  mew_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(sync)
  );

  mew_edge_det #(.W(NL), .TRAIL(TRAIL_ONLY)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .cur_i(sync[NL-1:0]), .evt_o(evt)
  );

  mew_wake #(.W(SW), .TRAIL(WAKE_TRAIL)) u_wake (
    .raw_i(raw), .sync_i(sync), .dis_i({swake_dis, mask}), .wake_o(wake_o)
  );

  assign rd_stat = reg_rd_i && (reg_addr_i == ADDR_STAT);

  // new event wins over a clearing read on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (rd_stat ? '0 : flag_q) | evt;
  end

  assign status = {sync[NL-1:0], flag_q};

  mew_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .status_i(status), .mask_o(mask),
    .msi_en_o(msi_en), .swake_dis_o(swake_dis), .rdata_o(reg_rdata_o)
  );

  assign irq_o = msi_en && |(flag_q & ~mask);
endmodule

// File: rtl/mew_checker.sv
module mew_checker
  import mew_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_wr_i,
  input logic          reg_rd_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic [DW-1:0] reg_rdata_o,
  input logic          irq_o,
  input logic [NL-1:0] flag_i,
  input logic [NL-1:0] evt_i
);
  logic rd_stat;
  logic unused_wdata;
  assign rd_stat = reg_rd_i && (reg_addr_i == ADDR_STAT);
  assign unused_wdata = ^reg_wdata_i[DW-1:NL];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (flag_i == '0 && !irq_o);
    end
  end

  p_event_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flag_i & $past(evt_i)) == $past(evt_i)));

  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stat |=> ((flag_i & $past(flag_i)) == $past(flag_i)));

  p_read_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && evt_i == '0) |=> (flag_i == '0));

  p_mask_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_MASK && reg_wdata_i[NL-1:0] == '1) |=> !irq_o);

  p_ier_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_IER && !reg_wdata_i[IER_MSI_BIT]) |=> !irq_o);

  p_rsvd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_MASK) |-> (reg_rdata_o[DW-1:NL] == '0));
endmodule

bind modem_evt_wake mew_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .irq_o(irq_o), .flag_i(flag_q), .evt_i(evt)
);

// File: tb/tb_modem_evt_wake.sv
module tb_modem_evt_wake;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cts = 0, dsr = 0, ri = 0, dcd = 0, sin = 1;
  logic wr = 0, rd = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq, wake;
  int checks = 0, errs = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_evt_wake dut (
    .clk_i(clk), .rst_ni(rst_n), .cts_i(cts), .dsr_i(dsr), .ri_i(ri), .dcd_i(dcd),
    .sin_i(sin), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [7:0] v);
    @(negedge clk); rd = 1; addr = a;
    #1 v = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic wait_edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    reg_read(0, v); chk("R1 mask", v, 8'h00);
    reg_read(1, v); chk("R1 ier", v, 8'h00);
    reg_read(3, v); chk("R1 swake", v, 8'h00);
    reg_read(2, v); chk("R1 status", v, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 wake", wake, 0);
  endtask

  task automatic t_cts_delta();
    logic [7:0] v;
    @(negedge clk) cts = 1;
    #1 chk("R7 wake on cts, ier off", wake, 1);
    wait_edges(2); chk("R7 wake drops", wake, 0);
    wait_edges(1); chk("R5 irq needs ier", irq, 0);
    wait_edges(4);
    reg_read(2, v); chk("R2 cts flag sticky", v, 8'h11);
    reg_read(2, v); chk("R4 cleared by read", v, 8'h10);
  endtask

  task automatic t_ier_irq();
    logic [7:0] v;
    reg_write(1, 8'hFF);
    reg_read(1, v); chk("R9 ier readback", v, 8'h08);
    @(negedge clk) dsr = 1;
    wait_edges(2); chk("R2 not before third edge", irq, 0);
    wait_edges(1); chk("R5 irq on dsr", irq, 1);
    reg_read(2, v); chk("R2 dsr flag", v, 8'h32);
    chk("R4 irq gone after read", irq, 0);
  endtask

  task automatic t_ri_trailing();
    logic [7:0] v;
    @(negedge clk) ri = 1;
    #1 chk("R3 no wake on ri rise", wake, 0);
    wait_edges(3); chk("R3 no irq on ri rise", irq, 0);
    reg_read(2, v); chk("R3 no flag on ri rise", v, 8'h70);
    @(negedge clk) ri = 0;
    #1 chk("R3 wake on ri fall", wake, 1);
    wait_edges(3); chk("R3 irq on ri fall", irq, 1);
    reg_read(2, v); chk("R3 ri flag", v, 8'h34);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    reg_write(0, 8'hFF);
    reg_read(0, v); chk("R9 mask reserved zero", v, 8'h0F);
    @(negedge clk) dcd = 1;
    #1 chk("R7 masked no wake", wake, 0);
    wait_edges(3); chk("R6 masked no irq", irq, 0);
    reg_read(2, v); chk("R6 masked flag still set", v, 8'hB8);
    reg_write(0, 8'h07);
    @(negedge clk) dcd = 0;
    #1 chk("R7 dcd unmasked wake", wake, 1);
    wait_edges(3); chk("R5 dcd unmasked irq", irq, 1);
    reg_read(2, v); chk("R2 dcd flag", v, 8'h38);
  endtask

  task automatic t_read_race();
    logic [7:0] v;
    reg_write(0, 8'h00);
    @(negedge clk) cts = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rd = 1; addr = 2;
    #1 v = rdata;
    @(negedge clk); rd = 0;
    chk("R4 race read before set", v, 8'h20);
    reg_read(2, v); chk("R4 event survives read", v, 8'h21);
  endtask

  task automatic t_serial();
    logic [7:0] v;
    @(negedge clk) sin = 0;
    #1 chk("R8 serial wake", wake, 1);
    wait_edges(2); chk("R8 serial wake drops", wake, 0);
    reg_write(3, 8'hFF);
    reg_read(3, v); chk("R9 swake readback", v, 8'h01);
    @(negedge clk) sin = 1;
    #1 chk("R8 serial wake disabled", wake, 0);
    wait_edges(3);
    reg_read(2, v); chk("R8 serial sets no flag", v, 8'h20);
    reg_write(2, 8'hFF);
    reg_read(2, v); chk("R9 status write ignored", v, 8'h20);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_cts_delta();
    t_ier_irq();
    t_ri_trailing();
    t_mask();
    t_read_race();
    t_serial();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule